// File: doc/BRIEF.md
# E3 Transmit Error Insertion Controller

This block sits in an E3 transmit path and corrupts the outgoing byte stream on purpose, so that a far-end receiver's alarm and error counters can be exercised. The frame content (framing word, BIP-8 parity byte, remote error indication bit) is produced upstream. Along with each data byte the block receives strobes that mark the two framing bytes, the parity byte and the byte that carries the remote error indication. The block decides only whether and how to flip bits at those marked places. Every byte leaves through one output register.

Three kinds of error can be inserted: framing, parity and remote error indication. Each kind has its own enable. Parity and remote error indication can run either once per trigger or on every frame. Framing errors follow one of four patterns, which flip either one bit or the whole framing word, in one frame or in four frames in a row. One shared trigger serves all enabled kinds. The trigger comes from a software bit or from an external pin, as chosen by a select input. Only a rising edge on the chosen source counts. Several edges that arrive before the next matching position yield a single error.

Top module: `e3_err_inject`

## Requirements
- R1: With no insertion taking place, `dout` equals the `din` of the previous clock cycle (one register of latency).
- R2: When `trig_sel` is 0, `sw_trig` is the trigger source and `pin_trig` is ignored. When `trig_sel` is 1, `pin_trig` is the source and `sw_trig` is ignored.
- R3: Only a 0-to-1 transition of the selected source requests an error, and a source held high requests nothing more. Any number of rising edges before the next matching position produce one error of each enabled kind.
- R4: Changing `trig_sel` so that it picks a source that is already high counts as a rising edge.
- R5: A parity error flips bit 7 of the byte marked by `mark_em` when `par_block` is 0, and all eight bits of that byte when `par_block` is 1.
- R6: With `par_en` and `par_cont` both set, every byte marked by `mark_em` carries a parity error, with or without a trigger.
- R7: A remote error indication error flips bit `REI_BIT` (default 3) of the byte marked by `mark_rei`. In single mode this happens once per trigger. With `rei_cont` set it happens on every marked byte.
- R8: Framing errors act on the two-byte framing word. The first framing byte is the first cycle of a two-cycle `mark_fa` pulse. `fa_pat` 00 flips bit 7 of the first framing byte in one frame. 01 flips all bits of both framing bytes in one frame. 10 is the single-bit error repeated in four consecutive frames. 11 is the word error repeated in four consecutive frames.
- R9: Triggers that arrive while a four-frame framing run is in progress, including the cycle in which the run starts, are dropped. They produce no extra framing error after the run ends.
- R10: A kind whose enable is 0 inserts nothing. A trigger seen while its enable is 0 is not stored. Clearing an enable discards any request of that kind still waiting.
- R11: After a synchronous active-high reset, `dout` is 0 and no request is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst | input | 1 | Synchronous active-high reset |
| din | input | 8 | Transmit byte from the framer |
| mark_fa | input | 1 | High on each of the two framing bytes |
| mark_em | input | 1 | High on the parity (EM) byte |
| mark_rei | input | 1 | High on the byte carrying the remote error indication bit |
| fa_en | input | 1 | Framing error enable |
| fa_pat | input | 2 | Framing error pattern |
| par_en | input | 1 | Parity error enable |
| par_block | input | 1 | 0: flip one bit, 1: flip the whole parity byte |
| par_cont | input | 1 | Continuous parity error mode |
| rei_en | input | 1 | Remote error indication error enable |
| rei_cont | input | 1 | Continuous remote error indication mode |
| trig_sel | input | 1 | 0: software trigger, 1: pin trigger |
| sw_trig | input | 1 | Software trigger bit |
| pin_trig | input | 1 | External manual insertion pin |
| dout | output | 8 | Transmit byte after insertion, registered |

## Verification
A reference model in the bench runs alongside the design on a synthetic 12-byte frame with random payload and is compared on every cycle. The trigger is exercised with several patterns. A level held high across many frames separates edge detection from level sensing. A burst of toggles inside one frame shows that requests collapse into one error. Pulses on the source that is not selected must have no effect, and switching the select onto a high pin must count as an edge. Each framing pattern runs for several frames, so a run that is one frame too short or too long is caught, and triggers fired in the middle of a four-frame run check that they are dropped. Enables are also cleared while a request is waiting, which checks that the request is discarded.

// File: rtl/e3ei_pkg.sv
package e3ei_pkg;

  typedef enum logic [1:0] {
    FE_BIT1  = 2'b00,
    FE_WORD1 = 2'b01,
    FE_BIT4  = 2'b10,
    FE_WORD4 = 2'b11
  } fe_pat_e;

  function automatic logic pat_is_word(input fe_pat_e p);
    return (p == FE_WORD1) || (p == FE_WORD4);
  endfunction

  function automatic logic pat_is_multi(input fe_pat_e p);
    return (p == FE_BIT4) || (p == FE_WORD4);
  endfunction

endpackage

// File: rtl/e3ei_trig.sv
module e3ei_trig (
  input  logic clk,
  input  logic rst,
  input  logic sel,
  input  logic sw,
  input  logic pin,
  output logic rise
);
  logic src;
  logic prev_q;

  // The previous value of the selected source, so a switch of sel onto a
  // high source is seen as an edge.
  always_comb src = sel ? pin : sw;
  always_comb rise = src & ~prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= src;
  end
endmodule

// File: rtl/e3ei_slot.sv
module e3ei_slot (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic cont,
  input  logic req,
  input  logic strobe,
  output logic hit
);
  logic pend_q;

  always_comb hit = strobe & en & (cont | pend_q);

  always_ff @(posedge clk) begin
    if (rst) pend_q <= 1'b0;
    else     pend_q <= en & ((pend_q & ~strobe) | req);
  end

  // R10: a disabled kind keeps no waiting request
  p_pend_drop_r10: assert property (@(posedge clk) disable iff (rst)
    !en |=> !pend_q);
endmodule

// File: rtl/e3ei_fa.sv
module e3ei_fa #(
  parameter int DW         = 8,
  parameter int RUN_FRAMES = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic [1:0]    pat,
  input  logic          req,
  input  logic          mark,
  output logic [DW-1:0] mask
);
  import e3ei_pkg::*;

  localparam int CW = (RUN_FRAMES > 2) ? $clog2(RUN_FRAMES) : 1;
  localparam logic [CW-1:0] RUN_LEFT = CW'(RUN_FRAMES - 1);
  localparam logic [DW-1:0] MSB_ONLY = {1'b1, {(DW-1){1'b0}}};

  fe_pat_e       pat_e;
  logic          prev_mark_q;
  logic [CW-1:0] left_q;
  logic          word_q;
  logic          second_q;
  logic          pend_q;
  logic          first, second, resume, start, hit, hit_word, blocked;

  always_comb begin
    pat_e    = fe_pat_e'(pat);
    first    = mark & ~prev_mark_q;
    second   = mark & prev_mark_q;
    resume   = first & en & (left_q != '0);
    start    = first & en & (left_q == '0) & pend_q;
    hit      = resume | start;
    hit_word = resume ? word_q : pat_is_word(pat_e);
    blocked  = (left_q != '0) | (start & pat_is_multi(pat_e));
    if (first && hit)          mask = hit_word ? '1 : MSB_ONLY;
    else if (second && second_q) mask = '1;
    else                       mask = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_mark_q <= 1'b0;
      left_q      <= '0;
      word_q      <= 1'b0;
      second_q    <= 1'b0;
      pend_q      <= 1'b0;
    end else begin
      prev_mark_q <= mark;
      second_q    <= first & hit & hit_word;
      pend_q      <= en & ((pend_q & ~start) | (req & ~blocked));
      if (start) word_q <= pat_is_word(pat_e);
      if (!en)         left_q <= '0;
      else if (start)  left_q <= pat_is_multi(pat_e) ? RUN_LEFT : '0;
      else if (resume) left_q <= left_q - 1'b1;
    end
  end

  // R9: no request survives into a running multi-frame burst
  p_no_pend_in_run_r9: assert property (@(posedge clk) disable iff (rst)
    (left_q != '0) |-> !pend_q);
endmodule

// File: rtl/e3_err_inject.sv
module e3_err_inject #(
  parameter int DW         = 8,
  parameter int RUN_FRAMES = 4,
  parameter int REI_BIT    = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] din,
  input  logic          mark_fa,
  input  logic          mark_em,
  input  logic          mark_rei,
  input  logic          fa_en,
  input  logic [1:0]    fa_pat,
  input  logic          par_en,
  input  logic          par_block,
  input  logic          par_cont,
  input  logic          rei_en,
  input  logic          rei_cont,
  input  logic          trig_sel,
  input  logic          sw_trig,
  input  logic          pin_trig,
  output logic [DW-1:0] dout
);
  localparam int NSLOT = 2;
  localparam logic [DW-1:0] MSB_ONLY = {1'b1, {(DW-1){1'b0}}};
  localparam logic [DW-1:0] REI_MASK = DW'(1) << REI_BIT;

  logic             rise;
  logic [DW-1:0]    fa_mask, mask;
  logic [NSLOT-1:0] s_en, s_cont, s_strobe, s_hit;
  logic [DW-1:0]    dout_q;

  e3ei_trig u_trig (
    .clk(clk), .rst(rst), .sel(trig_sel), .sw(sw_trig), .pin(pin_trig),
    .rise(rise)
  );

  e3ei_fa #(.DW(DW), .RUN_FRAMES(RUN_FRAMES)) u_fa (
    .clk(clk), .rst(rst), .en(fa_en), .pat(fa_pat), .req(rise),
    .mark(mark_fa), .mask(fa_mask)
  );

  // slot 0: parity byte, slot 1: remote error indication bit
  always_comb begin
    s_en     = {rei_en,   par_en};
    s_cont   = {rei_cont, par_cont};
    s_strobe = {mark_rei, mark_em};
  end

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    e3ei_slot u_slot (
      .clk(clk), .rst(rst), .en(s_en[g]), .cont(s_cont[g]), .req(rise),
      .strobe(s_strobe[g]), .hit(s_hit[g])
    );
  end

  always_comb begin
    mask = fa_mask;
    if (s_hit[0]) mask = mask | (par_block ? '1 : MSB_ONLY);
    if (s_hit[1]) mask = mask | REI_MASK;
  end

  always_ff @(posedge clk) begin
    if (rst) dout_q <= '0;
    else     dout_q <= din ^ mask;
  end

  assign dout = dout_q;

  // R1: untouched bytes pass with one cycle of latency
  p_idle_pass_r1: assert property (@(posedge clk) disable iff (rst)
    (mask == '0) |=> (dout == $past(din)));

  // R6: continuous parity corrupts every parity byte
  p_cont_par_r6: assert property (@(posedge clk) disable iff (rst)
    (par_en && par_cont && mark_em && !mark_fa && !mark_rei)
      |=> (dout != $past(din)));

  // R7: continuous remote indication flips its bit every time
  p_cont_rei_r7: assert property (@(posedge clk) disable iff (rst)
    (rei_en && rei_cont && mark_rei && !mark_fa && !mark_em)
      |=> (dout[REI_BIT] != $past(din[REI_BIT])));
endmodule

// File: tb/sim_e3_err_inject.sv
`timescale 1ns/1ps
module sim_e3_err_inject;
  localparam int FLEN = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [7:0] din = '0;
  logic mark_fa = 0, mark_em = 0, mark_rei = 0;
  logic fa_en = 0, par_en = 0, par_block = 0, par_cont = 0;
  logic rei_en = 0, rei_cont = 0, trig_sel = 0, sw_trig = 0, pin_trig = 0;
  logic [1:0] fa_pat = 2'b00;
  logic [7:0] dout;

  int nchk = 0, nerr = 0, ncyc = 0, pos = 0;
  string tag = "R11";

  // reference model state
  bit m_prev, m_pfa, m_ppar, m_prei, m_prevfa, m_secw, m_word;
  int m_left;
  logic [7:0] expv = '0;

  always #2 clk = ~clk;

  e3_err_inject u0 (
    .clk(clk), .rst(rst), .din(din), .mark_fa(mark_fa), .mark_em(mark_em),
    .mark_rei(mark_rei), .fa_en(fa_en), .fa_pat(fa_pat), .par_en(par_en),
    .par_block(par_block), .par_cont(par_cont), .rei_en(rei_en),
    .rei_cont(rei_cont), .trig_sel(trig_sel), .sw_trig(sw_trig),
    .pin_trig(pin_trig), .dout(dout)
  );

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  endtask

  always @(posedge clk) begin
    ncyc++;
    if (ncyc > 100000) begin
      nerr++;
      $display("FAIL watchdog: actual %0d cycles, expected fewer", ncyc);
      finish_run();
    end
  end

  task automatic model_step();
    bit src, rise, first, second, resume, start, w, blocked, ph, rh;
    logic [7:0] mask;
    if (rst) begin
      m_prev = 0; m_pfa = 0; m_ppar = 0; m_prei = 0; m_prevfa = 0;
      m_secw = 0; m_word = 0; m_left = 0; expv = '0;
      return;
    end
    src    = trig_sel ? pin_trig : sw_trig;
    rise   = src && !m_prev;
    first  = mark_fa && !m_prevfa;
    second = mark_fa && m_prevfa;
    mask   = '0;
    resume = first && fa_en && m_left > 0;
    start  = first && fa_en && m_left == 0 && m_pfa;
    w      = resume ? m_word : fa_pat[0];
    if (resume || start) mask |= w ? 8'hFF : 8'h80;
    else if (second && m_secw) mask |= 8'hFF;
    blocked = (m_left > 0) || (start && fa_pat[1]);
    m_pfa   = fa_en && ((m_pfa && !start) || (rise && !blocked));
    if (!fa_en)      m_left = 0;
    else if (start)  m_left = fa_pat[1] ? 3 : 0;
    else if (resume) m_left = m_left - 1;
    if (start) m_word = fa_pat[0];
    m_secw = (resume || start) && w;
    ph = mark_em && par_en && (par_cont || m_ppar);
    if (ph) mask |= par_block ? 8'hFF : 8'h80;
    m_ppar = par_en && ((m_ppar && !mark_em) || rise);
    rh = mark_rei && rei_en && (rei_cont || m_prei);
    if (rh) mask |= 8'h08;
    m_prei = rei_en && ((m_prei && !mark_rei) || rise);
    expv = din ^ mask;
    m_prev = src;
    m_prevfa = mark_fa;
  endtask

  // one byte: drive frame position, advance the model, check at negedge
  task automatic byte_step();
    din      = 8'($urandom);
    mark_fa  = (pos == 0) || (pos == 1);
    mark_em  = (pos == 5);
    mark_rei = (pos == 8);
    pos = (pos + 1) % FLEN;
    model_step();
    @(negedge clk);
    nchk++;
    if (dout !== expv) begin
      nerr++;
      $display("FAIL %s: dout actual %02h expected %02h", tag, dout, expv);
    end
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) byte_step();
  endtask

  task automatic pulse();
    if (trig_sel) pin_trig = 1; else sw_trig = 1;
    byte_step();
    if (trig_sel) pin_trig = 0; else sw_trig = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    model_step();
    nchk++;
    if (dout !== 8'h00) begin
      nerr++;
      $display("FAIL R11: reset dout actual %02h expected 00", dout);
    end
    rst = 0;

    tag = "R1";  run(2 * FLEN);

    tag = "R3";  par_en = 1;
    sw_trig = 1; run(3 * FLEN);                 // held level, one error
    sw_trig = 0; run(FLEN - pos + 1);           // now at byte 1
    sw_trig = 1; byte_step(); sw_trig = 0; byte_step();
    sw_trig = 1; byte_step(); sw_trig = 0;      // burst before byte 5
    run(2 * FLEN);

    tag = "R2";  pin_trig = 1; byte_step(); pin_trig = 0; run(FLEN);
    trig_sel = 1; sw_trig = 1; byte_step(); sw_trig = 0; run(FLEN);
    pulse(); run(FLEN);

    tag = "R4";  trig_sel = 0; pin_trig = 1; run(FLEN);
    trig_sel = 1; run(FLEN); pin_trig = 0; trig_sel = 0; run(FLEN);

    tag = "R5";  par_block = 1; pulse(); run(FLEN);
    tag = "R6";  par_cont = 1; run(3 * FLEN); par_cont = 0; par_block = 0;
    par_en = 0; run(FLEN);

    tag = "R7";  rei_en = 1; pulse(); run(2 * FLEN);
    rei_cont = 1; run(2 * FLEN); rei_cont = 0; rei_en = 0; run(FLEN);

    tag = "R8";  fa_en = 1;
    for (int p = 0; p < 4; p++) begin
      fa_pat = 2'(p); pulse(); run(6 * FLEN);
    end

    tag = "R9";  fa_pat = 2'b11; pulse(); run(2 * FLEN);
    pulse(); run(FLEN); pulse(); run(6 * FLEN);

    tag = "R10"; fa_en = 0; pulse(); run(FLEN);
    fa_en = 1; par_en = 1; rei_en = 1; run(2 * FLEN);
    run(FLEN - pos + 2);                        // byte 2, before parity byte
    pulse(); par_en = 0; byte_step(); par_en = 1; fa_en = 0; rei_en = 0;
    run(3 * FLEN);

    finish_run();
  end
endmodule